// File: doc/BRIEF.md
# Mailbox Transmit Buffer with Link-Loss Alarms

This block is the processor side of a small outbound message channel. Software fills an eight-byte message buffer through a simple synchronous register bus. It then raises a send-request bit, and the bytes are presented to an external serialiser. While the send is pending, the buffer is write-protected. The protection lifts when the far end acknowledges the message or when software withdraws the request. Software learns that the buffer is free again from a ready flag in the alarm register.

The same alarm register also reports link loss on two receive ports, A and B, whose lock inputs are asynchronous. Each loss bit is latched and clears when the register is read. A separate bit records any change of either loss indication. When a port newly loses lock, a single-cycle pulse goes to that port's remote-alarm register so that its stale contents are wiped. An interrupt-enable register with the same bit layout gates the alarm bits onto one interrupt line.

Top module: `msg_tx_regs`

## Requirements
- R1: After reset, the alarm register (0x0A) reads 0x01, the enable register (0x0B) reads 0x00, send_o is 0 and irq_o is 0.
- R2: Writes to 0x00..0x07 store message byte n at address n while the buffer is ready. The byte reads back at its address and appears on msg_o[8n+7:8n].
- R3: Writing 1 to bit 0 of 0x08 sets send_o and clears alarm bit 0 (ready). Register 0x08 reads the request in bit 0 and zeros above it.
- R4: While a send is pending, writes to 0x00..0x07 are ignored and the stored bytes stay unchanged.
- R5: A pulse on ack_i while a send is pending clears send_o and sets ready. A pulse on ack_i while no send is pending has no effect.
- R6: Writing 0 to bit 0 of 0x08 while a send is pending cancels it and sets ready.
- R7: Each lock input passes through a two-flop synchronizer, and loss means the synchronized lock is low. Port A loss latches alarm bit 2 and port B loss latches bit 1. A latched bit stays set after lock returns until the register is read.
- R8: A read strobe at 0x0A clears alarm bits 3:1 and leaves bit 0 unchanged. A loss present in the same cycle as the read keeps its bit set.
- R9: Alarm bit 3 is set whenever either synchronized loss indication changes, whether it rises or falls.
- R10: When port A loss becomes true, clr_rem_a_o pulses high for exactly one cycle. Port B behaves the same way with clr_rem_b_o.
- R11: Register 0x0B holds enables in bits 3:0 with the alarm layout. irq_o is high whenever any alarm bit and its enable are both set.
- R12: Reserved bits (7:4 of 0x0A and 0x0B) and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (clears read-sensitive alarm bits) |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| lock_a_i | input | 1 | Port A receive lock, asynchronous |
| lock_b_i | input | 1 | Port B receive lock, asynchronous |
| ack_i | input | 1 | Far-end acknowledge pulse |
| msg_o | output | 64 | Message bytes presented to the serialiser |
| send_o | output | 1 | Send request active |
| clr_rem_a_o | output | 1 | One-cycle clear toward port A remote alarms |
| clr_rem_b_o | output | 1 | One-cycle clear toward port B remote alarms |
| irq_o | output | 1 | Interrupt |

## Verification
The handshake is driven through four patterns:
- A fill-send-acknowledge round shows that the lock and its release both work.
- A write attempted mid-send tells a working lock apart from a missing one.
- A cancel and a stray acknowledge while idle tell the two release paths apart from spurious ones.

Lock inputs are dropped and restored with the alarm register read in several positions:
- A read after lock has returned shows that the bits were latched.
- A read while loss persists shows that the event wins over the clear.
- Separate port A and port B drops confirm that the bit positions and pulses are not swapped.

Enable masks that select the live ready bit, and then a latched loss bit, separate the interrupt gating for each bit.

// File: rtl/msg_tx_pkg.sv
package msg_tx_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int ALARM_W = 4;
  localparam int BIT_RDY  = 0;
  localparam int BIT_LOSB = 1;
  localparam int BIT_LOSA = 2;
  localparam int BIT_CHG  = 3;
  localparam logic [AW-1:0] ADDR_SEND  = 8'h08;
  localparam logic [AW-1:0] ADDR_ALARM = 8'h0A;
  localparam logic [AW-1:0] ADDR_IE    = 8'h0B;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= {W{RST_VAL}};
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {W{RST_VAL}};
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/msg_store.sv
module msg_store import msg_tx_pkg::*; #(
  parameter int N_BYTES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    ack_i,
  output logic [N_BYTES*DW-1:0]   bytes_o,
  output logic                    send_o
);
  logic [N_BYTES-1:0][DW-1:0] bytes_q;
  logic send_q;
  logic send_wr;

  assign send_wr = we_i && (addr_i == ADDR_SEND);

  // byte writes only land while no send is pending
  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        bytes_q[i] <= '0;
      else if (we_i && !send_q && (addr_i == AW'(i)))
        bytes_q[i] <= wdata_i;
    end
  end

  // acknowledge only counts while pending; it outranks a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                send_q <= 1'b0;
    else if (send_q && ack_i)   send_q <= 1'b0;
    else if (send_wr)           send_q <= wdata_i[0];
  end

  assign bytes_o = bytes_q;
  assign send_o  = send_q;

  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_q |=> $stable(bytes_q)); // R4
  AST_ACK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_q && ack_i) |=> !send_q); // R5
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!send_q && ack_i && !send_wr) |=> !send_q); // R5
  AST_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_q && !ack_i && send_wr && !wdata_i[0]) |=> !send_q); // R6
endmodule

// File: rtl/alarm_bank.sv
module alarm_bank import msg_tx_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         loss_i,     // [1]=port A, [0]=port B
  input  logic               ready_i,
  input  logic               rd_clr_i,
  input  logic               ie_we_i,
  input  logic [ALARM_W-1:0] ie_wdata_i,
  output logic [ALARM_W-1:0] alarm_o,
  output logic [ALARM_W-1:0] ie_o,
  output logic [1:0]         clr_rem_o,
  output logic               irq_o
);
  logic [1:0] loss_d_q;
  logic [1:0] los_q;
  logic chg_q;
  logic [ALARM_W-1:0] ie_q;
  logic toggle;

  assign toggle    = |(loss_i ^ loss_d_q);
  assign clr_rem_o = loss_i & ~loss_d_q;

  // a live event outranks the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loss_d_q <= '0;
      los_q    <= '0;
      chg_q    <= 1'b0;
      ie_q     <= '0;
    end else begin
      loss_d_q <= loss_i;
      los_q    <= loss_i | (los_q & {2{~rd_clr_i}});
      chg_q    <= toggle | (chg_q & ~rd_clr_i);
      if (ie_we_i) ie_q <= ie_wdata_i;
    end
  end

  always_comb begin
    alarm_o           = '0;
    alarm_o[BIT_RDY]  = ready_i;
    alarm_o[BIT_LOSB] = los_q[0];
    alarm_o[BIT_LOSA] = los_q[1];
    alarm_o[BIT_CHG]  = chg_q;
  end

  assign ie_o  = ie_q;
  assign irq_o = |(alarm_o & ie_q);

  AST_LOS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_q[1] && !rd_clr_i) |=> los_q[1]); // R7
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !(|loss_i) && !toggle) |=> (alarm_o[3:1] == 3'b000)); // R8
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && loss_i[1]) |=> los_q[1]); // R8
  AST_CHG_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle |=> chg_q); // R9
  AST_CLR_PULSE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rem_o[1] |=> !clr_rem_o[1]); // R10
  AST_CLR_PULSE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rem_o[0] |=> !clr_rem_o[0]); // R10
endmodule

// File: rtl/msg_tx_regs.sv
module msg_tx_regs import msg_tx_pkg::*; #(
  parameter int N_BYTES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  we_i,
  input  logic                  re_i,
  output logic [DW-1:0]         rdata_o,
  input  logic                  lock_a_i,
  input  logic                  lock_b_i,
  input  logic                  ack_i,
  output logic [N_BYTES*DW-1:0] msg_o,
  output logic                  send_o,
  output logic                  clr_rem_a_o,
  output logic                  clr_rem_b_o,
  output logic                  irq_o
);
  localparam int IW = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

  logic [1:0] lock_s;
  logic [1:0] clr_rem;
  logic [ALARM_W-1:0] alarm, ie;
  logic send;
  logic [N_BYTES-1:0][DW-1:0] bytes;

  lock_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lock_a_i, lock_b_i}),
    .q_o   (lock_s)
  );

  msg_store #(.N_BYTES(N_BYTES)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .ack_i  (ack_i),
    .bytes_o(bytes),
    .send_o (send)
  );

  alarm_bank u_alarm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .loss_i    (~lock_s),
    .ready_i   (~send),
    .rd_clr_i  (re_i && (addr_i == ADDR_ALARM)),
    .ie_we_i   (we_i && (addr_i == ADDR_IE)),
    .ie_wdata_i(wdata_i[ALARM_W-1:0]),
    .alarm_o   (alarm),
    .ie_o      (ie),
    .clr_rem_o (clr_rem),
    .irq_o     (irq_o)
  );

  assign msg_o       = bytes;
  assign send_o      = send;
  assign clr_rem_a_o = clr_rem[1];
  assign clr_rem_b_o = clr_rem[0];

  // unmapped addresses and reserved bits return zero (R12)
  always_comb begin
    rdata_o = '0;
    if (addr_i < AW'(N_BYTES))       rdata_o = bytes[addr_i[IW-1:0]];
    else if (addr_i == ADDR_SEND)    rdata_o[0] = send;
    else if (addr_i == ADDR_ALARM)   rdata_o[ALARM_W-1:0] = alarm;
    else if (addr_i == ADDR_IE)      rdata_o[ALARM_W-1:0] = ie;
  end

  AST_RDY_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send && ack_i) |=> alarm[BIT_RDY]); // R5
  AST_SEND_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!send && we_i && addr_i == ADDR_SEND && wdata_i[0]) |=> !alarm[BIT_RDY]); // R3
endmodule

// File: tb/sim_msg_tx_regs.sv
module sim_msg_tx_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic we = 1'b0, re = 1'b0, ack = 1'b0;
  logic lock_a = 1'b1, lock_b = 1'b1;
  logic [7:0] rdata;
  logic [63:0] msg;
  logic send, clr_a, clr_b, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msg_tx_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .lock_a_i(lock_a),
    .lock_b_i(lock_b), .ack_i(ack), .msg_o(msg), .send_o(send),
    .clr_rem_a_o(clr_a), .clr_rem_b_o(clr_b), .irq_o(irq)
  );

  // behavioural reference model
  logic [7:0] m_bytes [8];
  bit m_send, m_la, m_lb, m_lc;
  logic [3:0] m_ie;
  bit qa [$], qb [$];
  bit la_d, lb_d;

  function automatic bit loss_a(); return !qa[0]; endfunction
  function automatic bit loss_b(); return !qb[0]; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_bytes[i]) m_bytes[i] = 8'h00;
      m_send = 0; m_la = 0; m_lb = 0; m_lc = 0; m_ie = 4'h0;
      qa = '{1'b1, 1'b1}; qb = '{1'b1, 1'b1}; la_d = 0; lb_d = 0;
    end else begin
      bit rd, la, lb, ns;
      rd = re && addr == 8'h0A;
      la = loss_a(); lb = loss_b();
      m_la = la || (m_la && !rd);
      m_lb = lb || (m_lb && !rd);
      m_lc = (la != la_d) || (lb != lb_d) || (m_lc && !rd);
      la_d = la; lb_d = lb;
      void'(qa.pop_front()); qa.push_back(lock_a);
      void'(qb.pop_front()); qb.push_back(lock_b);
      if (we && addr < 8 && !m_send) m_bytes[addr[2:0]] = wdata;
      if (we && addr == 8'h0B) m_ie = wdata[3:0];
      if (m_send && ack) ns = 0;
      else if (we && addr == 8'h08) ns = wdata[0];
      else ns = m_send;
      m_send = ns;
    end
  end

  function automatic logic [3:0] m_alarm();
    return {m_lc, m_la, m_lb, !m_send};
  endfunction

  function automatic logic [7:0] m_rdata(logic [7:0] a);
    if (a < 8) return m_bytes[a[2:0]];
    if (a == 8'h08) return {7'b0, m_send};
    if (a == 8'h0A) return {4'b0, m_alarm()};
    if (a == 8'h0B) return {4'b0, m_ie};
    return 8'h00;
  endfunction

  function automatic logic [63:0] m_msg();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_bytes[i];
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(logic [7:0] a);
    if (a < 8) return "R2 rdata";
    if (a == 8'h08) return "R3 rdata";
    if (a == 8'h0A) return "R8 rdata";
    if (a == 8'h0B) return "R11 rdata";
    return "R12 rdata";
  endfunction

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(msg == m_msg(), "R2/R4 msg_o", msg, m_msg());
      chk(send == m_send, "R3 send_o", send, m_send);
      chk(irq == |(m_alarm() & m_ie), "R11 irq_o", irq, |(m_alarm() & m_ie));
      chk(clr_a == (loss_a() && !la_d), "R10 clr_rem_a_o", clr_a, loss_a() && !la_d);
      chk(clr_b == (loss_b() && !lb_d), "R10 clr_rem_b_o", clr_b, loss_b() && !lb_d);
      chk(rdata == m_rdata(addr), rd_tag(addr), rdata, m_rdata(addr));
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_clr();
    @(negedge clk); re = 1; addr = 8'h0A;
    @(negedge clk); re = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic peek(logic [7:0] a, logic [7:0] exp, string tag);
    addr = a; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    // R1 reset state
    peek(8'h0A, 8'h01, "R1 alarm reset");
    peek(8'h0B, 8'h00, "R1 enable reset");
    chk(send == 0, "R1 send_o reset", send, 0);
    chk(irq == 0, "R1 irq_o reset", irq, 0);

    // R2 fill buffer
    for (int i = 0; i < 8; i++) wr(8'(i), 8'(8'h10 + 8'h11 * i));
    cyc(1);
    peek(8'h05, 8'h65, "R2 byte5 readback");
    chk(msg == 64'h8776_6554_4332_2110, "R2 msg_o layout", msg, 64'h8776_6554_4332_2110);

    // R3 send
    wr(8'h08, 8'h01); cyc(1);
    chk(send == 1, "R3 send_o set", send, 1);
    peek(8'h0A, 8'h00, "R3 ready cleared");
    peek(8'h08, 8'h01, "R3 send reg read");

    // R4 locked
    wr(8'h03, 8'hEE); cyc(1);
    peek(8'h03, 8'h43, "R4 write ignored");

    // R5 acknowledge
    pulse_ack(); cyc(1);
    chk(send == 0, "R5 ack clears send", send, 0);
    peek(8'h0A, 8'h01, "R5 ready set");
    pulse_ack(); cyc(1);
    chk(send == 0, "R5 idle ack ignored", send, 0);
    wr(8'h03, 8'hEE); cyc(1);
    peek(8'h03, 8'hEE, "R2 write after unlock");

    // R6 cancel
    wr(8'h08, 8'h01); cyc(2);
    wr(8'h08, 8'h00); cyc(1);
    chk(send == 0, "R6 cancel clears send", send, 0);
    peek(8'h0A, 8'h01, "R6 ready after cancel");

    // R7/R9/R10 port A loss
    @(negedge clk); lock_a = 0; addr = 8'h09;
    @(negedge clk); chk(clr_a == 0, "R7 sync delay clr_a", clr_a, 0);
    @(negedge clk); chk(clr_a == 1, "R10 clr_a pulse", clr_a, 1);
    chk(clr_b == 0, "R10 clr_b quiet", clr_b, 0);
    @(negedge clk); chk(clr_a == 0, "R10 clr_a single cycle", clr_a, 0);
    cyc(2); lock_a = 1; cyc(4);
    peek(8'h0A, 8'h0D, "R7 R9 latched after return");
    rd_clr(); cyc(1);
    peek(8'h0A, 8'h01, "R8 read clears 3:1 keeps 0");

    // R8 event wins against read
    @(negedge clk); lock_a = 0; cyc(4);
    rd_clr(); cyc(1);
    peek(8'h0A, 8'h05, "R8 event wins");
    @(negedge clk); lock_a = 1; cyc(4);
    rd_clr(); cyc(1);
    peek(8'h0A, 8'h01, "R8 cleared after return");

    // R7 port B
    @(negedge clk); lock_b = 0; cyc(4);
    peek(8'h0A, 8'h0B, "R7 port B bit1");

    // R11/R12 enables
    wr(8'h0B, 8'hF0); cyc(1);
    peek(8'h0B, 8'h00, "R12 enable reserved bits");
    chk(irq == 0, "R11 irq masked", irq, 0);
    wr(8'h0B, 8'h02); cyc(1);
    chk(irq == 1, "R11 irq on loss B", irq, 1);
    @(negedge clk); lock_b = 1; cyc(4);
    rd_clr(); cyc(1);
    chk(irq == 0, "R11 irq drops after clear", irq, 0);
    wr(8'h0B, 8'h01); cyc(1);
    chk(irq == 1, "R11 irq on ready", irq, 1);
    wr(8'h08, 8'h01); cyc(1);
    chk(irq == 0, "R11 irq drops while pending", irq, 0);
    pulse_ack(); cyc(1);

    // R12 unmapped
    peek(8'h09, 8'h00, "R12 addr 09");
    peek(8'h0C, 8'h00, "R12 addr 0C");
    peek(8'hFF, 8'h00, "R12 addr FF");
    cyc(2);
    finish_run();
  end
endmodule